// File: doc/BRIEF.md
# Comparator-or-Digital Port Input Router

This block sits on the input side of a three-pin port that runs either as a pair of analog comparators or as three plain digital inputs, chosen by a single mode bit. In analog mode, two pins deliver comparator results, which are modelled here as digital result inputs. The third pin carries the comparator reference. Because that pin then carries no data, its input-register slot and its interrupt request are taken over by the level of the stop-recovery source set, which does not include these three pins. In digital mode, the three pins are sampled directly and the reference pin's falling edge raises the interrupt.

All pin-side inputs pass through a two-flop synchroniser. The interrupt is a one-cycle pulse on a falling edge of the selected source. It is held off for two cycles after any mode change, so that switching sources cannot look like an edge. While the chip is in stop mode, the comparator results are forced inactive. A stop wake-up request is formed from the recovery source set and, only in digital mode, from the port pins. Each comparator result can be driven onto its own output pin under its own enable bit. When the enable is clear, the pin shows its port data value. There is no streaming data path: every pin is a plain level, so no valid/ready handshake applies.

Top module: `cmp_port_router`

## Requirements
- R1: In digital mode (analog_mode=0), in_bits equals {pin_ref, pin_b, pin_a} (bit 2 = reference pin, bit 1 = pin_b, bit 0 = pin_a), three clock edges after the pins change.
- R2: In analog mode (analog_mode=1) outside stop, in_bits[0] equals cmp_a, in_bits[1] equals cmp_b, and in_bits[2] equals rec_src_n. The level of pin_ref never reaches in_bits.
- R3: In digital mode, a falling edge on pin_ref produces irq high for exactly one cycle, visible after the third rising clock edge following the change.
- R4: In analog mode, irq follows falling edges of rec_src_n, and edges on pin_ref produce no irq.
- R5: No irq is produced on the edge where a mode change is taken or on the two edges that follow it, even when the source switch looks like a falling edge.
- R6: While stop_mode=1, in_bits[1:0] reads 0 in analog mode, and a cmp_pins bit whose enable is set reads 0.
- R7: stop_wake is 0 outside stop. In stop, it is 1 when rec_src_n is low, or when the port is in digital mode with pin_wake_en=1 and any of the three pins is low. Pin levels are ignored for wake-up in analog mode.
- R8: cmp_pins[i] shows the stop-gated comparator result i when cmp_out_en[i]=1 and port_dr[i] otherwise. The two enables act independently. In digital mode, an enabled pin reads 0.
- R9: During reset, irq, in_bits and stop_wake are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| analog_mode | input | 1 | 1 = comparator mode, 0 = digital mode |
| stop_mode | input | 1 | Chip is in stop mode |
| pin_a | input | 1 | Port pin A digital level |
| pin_b | input | 1 | Port pin B digital level |
| pin_ref | input | 1 | Reference pin digital level |
| cmp_a | input | 1 | Comparator A result |
| cmp_b | input | 1 | Comparator B result |
| rec_src_n | input | 1 | Combined stop-recovery source level, active low |
| pin_wake_en | input | 1 | Allow the port pins to wake from stop in digital mode |
| cmp_out_en | input | 2 | Per-pin comparator output enable |
| port_dr | input | 2 | Port data register values for the two output pins |
| in_bits | output | 3 | Port input register view |
| cmp_pins | output | 2 | Output pin levels |
| irq | output | 1 | One-cycle interrupt request pulse |
| stop_wake | output | 1 | Stop wake-up request |

## Verification
Random level patterns on all pins are applied under a fixed mode and stop setting and held until they settle. This separates the digital mapping from the analog mapping, and the gated comparator results from the raw ones. Across consecutive patterns, falls on the unselected source must raise no interrupt while falls on the selected source must raise exactly one. This shows which source the mode bit routes. Directed cases pin down the exact interrupt latency, the silence around a mode switch that looks like an edge, and stop-mode gating with the output enables set one at a time.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  typedef struct packed {
    logic rec_n;
    logic cmp_b;
    logic cmp_a;
    logic ref_p;
    logic pb;
    logic pa;
  } cpr_pins_t;
  localparam int PIN_W = $bits(cpr_pins_t);
endpackage

// File: rtl/cpr_sync.sv
module cpr_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cpr_irq.sv
module cpr_irq #(
  parameter int MASK_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_req,
  input  logic ref_s,
  input  logic rec_s,
  output logic mode_q,
  output logic irq
);
  localparam int CW = $clog2(MASK_CYC + 1);

  logic [CW-1:0] hold_cnt;
  logic          prev_src;
  logic          cur_src;
  logic          mode_chg;

  assign mode_chg = (mode_req != mode_q);
  assign cur_src  = mode_q ? rec_s : ref_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      hold_cnt <= '0;
      prev_src <= 1'b1;
      irq      <= 1'b0;
    end else begin
      mode_q   <= mode_req;
      prev_src <= cur_src;
      if (mode_chg)
        hold_cnt <= CW'(MASK_CYC);
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - CW'(1);
      irq <= prev_src & ~cur_src & ~mode_chg & (hold_cnt == '0);
    end
  end

  // R3
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  mode_switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> !irq);

  // R5
  mode_switch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |=> !irq);
endmodule

// File: rtl/cpr_route.sv
module cpr_route #(
  parameter int NCMP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_q,
  input  logic            stop_mode,
  input  logic            pa_s,
  input  logic            pb_s,
  input  logic            ref_s,
  input  logic [NCMP-1:0] cmp_s,
  input  logic            rec_s,
  input  logic            pin_wake_en,
  input  logic [NCMP-1:0] out_en,
  input  logic [NCMP-1:0] port_dr,
  output logic [NCMP:0]   in_bits,
  output logic [NCMP-1:0] cmp_pins,
  output logic            stop_wake
);
  logic [NCMP-1:0] cmp_live;
  logic [NCMP:0]   in_nxt;
  logic            pin_low;

  assign cmp_live = cmp_s & {NCMP{mode_q & ~stop_mode}};
  assign in_nxt   = mode_q ? {rec_s, cmp_live} : {ref_s, pb_s, pa_s};
  assign pin_low  = ~(pa_s & pb_s & ref_s);
  assign stop_wake = stop_mode & (~rec_s | (~mode_q & pin_wake_en & pin_low));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_bits <= '0;
    else        in_bits <= in_nxt;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_out
    assign cmp_pins[i] = out_en[i] ? cmp_live[i] : port_dr[i];

    // R8
    dig_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && out_en[i]) |-> !cmp_pins[i]);
  end

  // R6
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && mode_q) |=> (in_bits[NCMP-1:0] == '0));

  // R7
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_mode |-> !stop_wake);
endmodule

// File: rtl/cmp_port_router.sv
module cmp_port_router #(
  parameter int SYNC_STAGES = 2,
  parameter int MASK_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       analog_mode,
  input  logic       stop_mode,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       pin_ref,
  input  logic       cmp_a,
  input  logic       cmp_b,
  input  logic       rec_src_n,
  input  logic       pin_wake_en,
  input  logic [1:0] cmp_out_en,
  input  logic [1:0] port_dr,
  output logic [2:0] in_bits,
  output logic [1:0] cmp_pins,
  output logic       irq,
  output logic       stop_wake
);
  import cpr_pkg::*;

  cpr_pins_t raw, syn;
  logic      mode_q;

  assign raw = '{rec_n: rec_src_n, cmp_b: cmp_b, cmp_a: cmp_a,
                 ref_p: pin_ref, pb: pin_b, pa: pin_a};

  cpr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  cpr_irq #(.MASK_CYC(MASK_CYC)) u_irq (
    .clk(clk), .rst_n(rst_n), .mode_req(analog_mode),
    .ref_s(syn.ref_p), .rec_s(syn.rec_n), .mode_q(mode_q), .irq(irq)
  );

  cpr_route #(.NCMP(2)) u_route (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .stop_mode(stop_mode),
    .pa_s(syn.pa), .pb_s(syn.pb), .ref_s(syn.ref_p),
    .cmp_s({syn.cmp_b, syn.cmp_a}), .rec_s(syn.rec_n),
    .pin_wake_en(pin_wake_en), .out_en(cmp_out_en), .port_dr(port_dr),
    .in_bits(in_bits), .cmp_pins(cmp_pins), .stop_wake(stop_wake)
  );
endmodule

// File: tb/cmp_port_router_bench.sv
module cmp_port_router_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic analog_mode = 0, stop_mode = 0, pin_a = 1, pin_b = 1, pin_ref = 1;
  logic cmp_a = 0, cmp_b = 0, rec_src_n = 1, pin_wake_en = 0;
  logic [1:0] cmp_out_en = 0, port_dr = 0;
  logic [2:0] in_bits;
  logic [1:0] cmp_pins;
  logic irq, stop_wake;

  int checks = 0, errors = 0, irq_seen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmp_port_router u_cmp_port_router (.*);

  always @(posedge clk) if (irq) irq_seen++;

  function automatic logic [2:0] exp_in(logic m, logic s);
    if (m) return {rec_src_n, cmp_b & ~s, cmp_a & ~s};
    return {pin_ref, pin_b, pin_a};
  endfunction

  function automatic logic [1:0] exp_pins(logic m, logic s);
    logic [1:0] c;
    c = {cmp_b, cmp_a} & {2{m & ~s}};
    return {cmp_out_en[1] ? c[1] : port_dr[1], cmp_out_en[0] ? c[0] : port_dr[0]};
  endfunction

  function automatic logic exp_wake(logic m, logic s);
    return s & (~rec_src_n | (~m & pin_wake_en & ~(pin_a & pin_b & pin_ref)));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic old_sel, new_sel, m_prev;
    cyc(3);
    // R9 reset state
    chk("R9 irq", irq, 0);
    chk("R9 in_bits", in_bits, 0);
    chk("R9 stop_wake", stop_wake, 0);
    rst_n = 1;
    cyc(6);

    // R3 exact latency, digital mode
    pin_ref = 0;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    chk("R3 pulse", irq, 1);
    @(posedge clk); #1;
    chk("R3 one cycle", irq, 0);
    cyc(3);
    pin_ref = 1; cyc(5);

    // R5 switch to analog with rec low: source looks like a fall
    rec_src_n = 0; cyc(5);
    irq_seen = 0;
    analog_mode = 1; cyc(8);
    chk("R5 masked switch", irq_seen, 0);
    // R4 ref ignored in analog
    irq_seen = 0;
    pin_ref = 0; cyc(5); pin_ref = 1; cyc(5);
    chk("R4 ref ignored", irq_seen, 0);
    // R4 rec fall raises irq
    rec_src_n = 1; cyc(5); irq_seen = 0;
    rec_src_n = 0; cyc(6);
    chk("R4 rec irq", irq_seen, 1);

    // R6 stop gating with one enable at a time
    cmp_a = 1; cmp_b = 1; port_dr = 2'b11; cmp_out_en = 2'b01; stop_mode = 1; cyc(5);
    chk("R6 in_bits", in_bits[1:0], 0);
    chk("R6 pin0", cmp_pins, 2'b10);
    stop_mode = 0; cyc(5);
    chk("R8 pin0 live", cmp_pins, 2'b11);
    cmp_out_en = 2'b10; port_dr = 2'b00; cyc(2);
    chk("R8 pin1 live", cmp_pins, 2'b10);

    // random phase
    m_prev = analog_mode;
    for (int it = 0; it < 400; it++) begin
      logic m_new;
      if (it == 0) void'($urandom(32'h5eed));
      m_new = ($urandom % 8 == 0) ? ~m_prev : m_prev;
      old_sel = m_prev ? rec_src_n : pin_ref;
      irq_seen = 0;
      analog_mode = m_new;
      stop_mode = $urandom; pin_a = $urandom; pin_b = $urandom; pin_ref = $urandom;
      cmp_a = $urandom; cmp_b = $urandom; rec_src_n = $urandom;
      pin_wake_en = $urandom; cmp_out_en = $urandom; port_dr = $urandom;
      cyc(6);
      new_sel = m_new ? rec_src_n : pin_ref;
      if (m_new == m_prev)
        chk(m_new ? "R4 rand irq" : "R3 rand irq", irq_seen, {31'd0, old_sel & ~new_sel});
      else
        chk("R5 rand switch", irq_seen, 0);
      chk(m_new ? "R2 rand in_bits" : "R1 rand in_bits", in_bits, exp_in(m_new, stop_mode));
      chk("R8 rand pins", cmp_pins, exp_pins(m_new, stop_mode));
      chk("R7 rand wake", stop_wake, exp_wake(m_new, stop_mode));
      m_prev = m_new;
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule